// File: doc/BRIEF.md
# Ternary Unary Function Unit

This block is a purely combinational evaluator of single-input ternary functions. Each trit travels on a two-bit binary code. A selector picks one of the 27 possible mappings from a trit to a trit. The selector is read as a three-digit base-3 number: its least significant digit is the result for input 0, its middle digit the result for input 1, and its most significant digit the result for input 2. The selected result appears on one output.

Five more outputs are always driven from the same input trit, whatever the selector holds. They carry the standard inverter, the two threshold inverters, and the increment and decrement cycling inverters. Two flags report an input trit whose code is not legal and a selector that names no function. A datapath can therefore use the same block both as a general function lookup and as a source of the common inverters.

Top module: `tern_unary_unit`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. For a legal trit x and a selector n in 0..26, `sel_out` equals digit x of n written in base 3, where digit 0 is the least significant. `sel_out` never carries 2'b11.
- R2: A selector value of 27 or more sets `bad_sel` and forces `sel_out` to 2'b00. A value from 0 to 26 clears `bad_sel`. `bad_sel` depends only on the selector.
- R3: The input code 2'b11 sets `bad_trit`, and all six trit outputs read 2'b00. A legal code clears `bad_trit`.
- R4: Selectors 0, 13 and 26 give the constants 0, 1 and 2. Selector 21 returns the input unchanged.
- R5: `std_inv_out` maps 0 to 2, 1 to 1 and 2 to 0 (function 5).
- R6: `neg_inv_out` maps 0 to 2, 1 to 0 and 2 to 0 (function 2).
- R7: `pos_inv_out` maps 0 to 2, 1 to 2 and 2 to 0 (function 8).
- R8: `inc_cyc_out` gives (x + 1) mod 3 (function 7).
- R9: `dec_cyc_out` gives (x + 2) mod 3 (function 11).
- R10: Feeding `dec_cyc_out` back as the input yields the increment of the first input on `dec_cyc_out`. Feeding `inc_cyc_out` back yields the decrement on `inc_cyc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| trit_in | input | 2 | Input trit code |
| func_sel | input | SW (5) | Base-3 function index |
| sel_out | output | 2 | Result of the selected function |
| std_inv_out | output | 2 | Standard inverter result |
| neg_inv_out | output | 2 | Negative-threshold inverter result |
| pos_inv_out | output | 2 | Positive-threshold inverter result |
| inc_cyc_out | output | 2 | Increment cycling inverter result |
| dec_cyc_out | output | 2 | Decrement cycling inverter result |
| bad_trit | output | 1 | Input code 2'b11 seen |
| bad_sel | output | 1 | Selector above 26 |

## Verification
The bench builds the block with the default selector width of five bits. At that width it can sweep every selector code, including the five codes from 27 to 31 that name no function, against all four input codes. This covers the full 27-by-3 function table, the out-of-range selector path and the illegal trit path. Chained checks feed a cycling output back as the input to confirm that two decrements equal one increment, and that two increments equal one decrement.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int unsigned TRIT_W  = 2;
  localparam int unsigned RADIX   = 3;
  localparam int unsigned N_FUNCS = RADIX * RADIX * RADIX;
  localparam int unsigned SEL_W   = $clog2(N_FUNCS);
  localparam int unsigned N_FIXED = 5;

  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t T_ZERO    = 2'b00;
  localparam trit_t T_ONE     = 2'b01;
  localparam trit_t T_TWO     = 2'b10;
  localparam trit_t T_ILLEGAL = 2'b11;

  // base-3 digit number pos of idx
  function automatic trit_t fn_digit(input int unsigned idx, input int pos);
    int unsigned v;
    v = idx;
    case (pos)
      0:       v = v % RADIX;
      1:       v = (v / RADIX) % RADIX;
      default: v = (v / (RADIX * RADIX)) % RADIX;
    endcase
    return trit_t'(v);
  endfunction

  function automatic trit_t fn_inc(input trit_t x);
    case (x)
      T_ZERO:  return T_ONE;
      T_ONE:   return T_TWO;
      T_TWO:   return T_ZERO;
      default: return T_ZERO;
    endcase
  endfunction

  function automatic trit_t fn_dec(input trit_t x);
    case (x)
      T_ZERO:  return T_TWO;
      T_ONE:   return T_ZERO;
      T_TWO:   return T_ONE;
      default: return T_ZERO;
    endcase
  endfunction

  // table index of each dedicated inverter: std, neg, pos, inc, dec
  function automatic int unsigned fn_fixed_index(input int k);
    case (k)
      0:       return 5;
      1:       return 2;
      2:       return 8;
      3:       return 7;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/tern_in_check.sv
module tern_in_check
  import tern_pkg::*;
(
  input  trit_t x,
  output logic  x_ok,
  output trit_t x_clean
);
  assign x_ok    = (x != T_ILLEGAL);
  assign x_clean = x_ok ? x : T_ZERO;

  always_comb begin
    AST_CLEAN_LEGAL: assert (x_clean != T_ILLEGAL); // R3
  end
endmodule

// File: rtl/tern_lut_eval.sv
module tern_lut_eval
  import tern_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic [SW-1:0] sel,
  input  trit_t         x,
  input  logic          x_ok,
  output trit_t         y
);
  localparam int unsigned LAST = N_FUNCS - 1;

  int unsigned sel_u;
  logic        in_range;
  trit_t       dig [RADIX];

  assign sel_u    = 32'(sel);
  assign in_range = (sel_u <= LAST);

  generate
    for (genvar g = 0; g < RADIX; g++) begin : g_dig
      assign dig[g] = fn_digit(sel_u, g);
    end
  endgenerate

  always_comb begin
    y = T_ZERO;
    if (x_ok && in_range) begin
      case (x)
        T_ZERO:  y = dig[0];
        T_ONE:   y = dig[1];
        T_TWO:   y = dig[2];
        default: y = T_ZERO;
      endcase
    end
  end

  always_comb begin
    AST_DIGIT_LEGAL: assert (y != T_ILLEGAL); // R1
  end
endmodule

// File: rtl/tern_fixed_bank.sv
module tern_fixed_bank
  import tern_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  trit_t                     x,
  input  logic                      x_ok,
  output logic [N_FIXED*TRIT_W-1:0] y_vec
);
  generate
    for (genvar g = 0; g < N_FIXED; g++) begin : g_fix
      localparam logic [SW-1:0] IDX = SW'(fn_fixed_index(g));
      trit_t y_one;
      tern_lut_eval #(.SW(SW)) eval_i (
        .sel  (IDX),
        .x    (x),
        .x_ok (x_ok),
        .y    (y_one)
      );
      assign y_vec[g*TRIT_W +: TRIT_W] = y_one;
    end
  endgenerate
endmodule

// File: rtl/tern_unary_unit.sv
module tern_unary_unit
  import tern_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic [1:0]    trit_in,
  input  logic [SW-1:0] func_sel,
  output logic [1:0]    sel_out,
  output logic [1:0]    std_inv_out,
  output logic [1:0]    neg_inv_out,
  output logic [1:0]    pos_inv_out,
  output logic [1:0]    inc_cyc_out,
  output logic [1:0]    dec_cyc_out,
  output logic          bad_trit,
  output logic          bad_sel
);
  localparam int unsigned LAST = N_FUNCS - 1;

  logic                      x_ok;
  trit_t                     x_clean;
  trit_t                     sel_y;
  logic [N_FIXED*TRIT_W-1:0] fix_vec;

  tern_in_check chk_i (
    .x       (trit_in),
    .x_ok    (x_ok),
    .x_clean (x_clean)
  );

  tern_lut_eval #(.SW(SW)) sel_i (
    .sel  (func_sel),
    .x    (x_clean),
    .x_ok (x_ok),
    .y    (sel_y)
  );

  tern_fixed_bank #(.SW(SW)) bank_i (
    .x     (x_clean),
    .x_ok  (x_ok),
    .y_vec (fix_vec)
  );

  assign sel_out     = sel_y;
  assign std_inv_out = fix_vec[0*TRIT_W +: TRIT_W];
  assign neg_inv_out = fix_vec[1*TRIT_W +: TRIT_W];
  assign pos_inv_out = fix_vec[2*TRIT_W +: TRIT_W];
  assign inc_cyc_out = fix_vec[3*TRIT_W +: TRIT_W];
  assign dec_cyc_out = fix_vec[4*TRIT_W +: TRIT_W];
  assign bad_trit    = !x_ok;
  assign bad_sel     = (32'(func_sel) > LAST);

  always_comb begin
    if (bad_trit) begin
      AST_BAD_TRIT_QUIET: assert ((sel_out | std_inv_out | neg_inv_out | pos_inv_out
                                   | inc_cyc_out | dec_cyc_out) == 2'b00); // R3
    end
    if (bad_sel) begin
      AST_BAD_SEL_ZERO: assert (sel_out == T_ZERO); // R2
    end
    if (!bad_trit) begin
      AST_STD_MIRROR: assert (std_inv_out == 2'(T_TWO - trit_in)); // R5
      AST_NEG_BELOW_STD: assert (neg_inv_out <= std_inv_out); // R6
      AST_POS_ABOVE_STD: assert (pos_inv_out >= std_inv_out); // R7
      AST_INC_STEP: assert (inc_cyc_out == fn_inc(trit_in)); // R8
      AST_DEC_STEP: assert (dec_cyc_out == fn_dec(trit_in)); // R9
      AST_DEC_TWICE: assert (fn_dec(dec_cyc_out) == inc_cyc_out); // R10
      AST_INC_TWICE: assert (fn_inc(inc_cyc_out) == dec_cyc_out); // R10
    end
    if (!bad_trit && 32'(func_sel) == 21) begin
      AST_IDENTITY: assert (sel_out == trit_in); // R4
    end
  end
endmodule

// File: tb/tern_unary_unit_tb_top.sv
module tern_unary_unit_tb_top;
  localparam int SW = 5;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    trit_in = 2'b00;
  logic [SW-1:0] func_sel = '0;
  logic [1:0]    sel_out, std_inv_out, neg_inv_out, pos_inv_out, inc_cyc_out, dec_cyc_out;
  logic          bad_trit, bad_sel;

  tern_unary_unit #(.SW(SW)) dut_i (
    .trit_in     (trit_in),
    .func_sel    (func_sel),
    .sel_out     (sel_out),
    .std_inv_out (std_inv_out),
    .neg_inv_out (neg_inv_out),
    .pos_inv_out (pos_inv_out),
    .inc_cyc_out (inc_cyc_out),
    .dec_cyc_out (dec_cyc_out),
    .bad_trit    (bad_trit),
    .bad_sel     (bad_sel)
  );

  typedef struct {
    logic [1:0]  x;
    logic [4:0]  s;
    logic [13:0] exp_vec;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;

  // reference model written from the requirements
  function automatic int ref_pick(int s, int x);
    int v = s;
    for (int i = 0; i < x; i++) v = v / 3;
    return v % 3;
  endfunction
  function automatic int ref_std(int x); return 2 - x; endfunction
  function automatic int ref_neg(int x); return (x == 0) ? 2 : 0; endfunction
  function automatic int ref_pos(int x); return (x == 2) ? 0 : 2; endfunction
  function automatic int ref_inc(int x); return (x == 2) ? 0 : x + 1; endfunction
  function automatic int ref_dec(int x); return (x == 0) ? 2 : x - 1; endfunction

  function automatic logic [13:0] expect_vec(int x, int s);
    logic [1:0] so, st, ne, po, ic, dc;
    logic bt, bs;
    bs = (s > 26);
    bt = (x == 3);
    if (bt) begin
      so = 0; st = 0; ne = 0; po = 0; ic = 0; dc = 0;
    end else begin
      so = bs ? 2'd0 : 2'(ref_pick(s, x));
      st = 2'(ref_std(x)); ne = 2'(ref_neg(x)); po = 2'(ref_pos(x));
      ic = 2'(ref_inc(x)); dc = 2'(ref_dec(x));
    end
    return {so, st, ne, po, ic, dc, bt, bs};
  endfunction

  task automatic drive(input int x, input int s);
    item_t it;
    @(posedge clk);
    #1;
    trit_in = 2'(x);
    func_sel = SW'(s);
    it.x = 2'(x);
    it.s = 5'(s);
    it.exp_vec = expect_vec(x, s);
    if (x == 3) it.tag = "R3";
    else if (s > 26) it.tag = "R2";
    else if (s == 0 || s == 13 || s == 26 || s == 21) it.tag = "R4 R1 R5 R6 R7 R8 R9";
    else it.tag = "R1 R5 R6 R7 R8 R9";
    q.push_back(it);
  endtask

  // monitor: pop and compare mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [13:0] act;
      it = q.pop_front();
      act = {sel_out, std_inv_out, neg_inv_out, pos_inv_out, inc_cyc_out, dec_cyc_out,
             bad_trit, bad_sel};
      n_checks++;
      if (act !== it.exp_vec) begin
        n_fail++;
        $display("FAIL %s x=%0d sel=%0d actual=%b expected=%b", it.tag, it.x, it.s,
                 act, it.exp_vec);
      end
    end
  end

  task automatic chain_check(input int x, input bit use_dec);
    logic [1:0] first, second;
    int want;
    @(negedge clk);
    #1;
    trit_in = 2'(x);
    #1;
    first = use_dec ? dec_cyc_out : inc_cyc_out;
    trit_in = first;
    #1;
    second = use_dec ? dec_cyc_out : inc_cyc_out;
    want = use_dec ? ref_inc(x) : ref_dec(x);
    n_checks++;
    if (second !== 2'(want)) begin
      n_fail++;
      $display("FAIL R10 x=%0d twice-%s actual=%0d expected=%0d", x,
               use_dec ? "dec" : "inc", second, want);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * WATCHDOG_CYC);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // reset state: zero inputs give function 0 on sel_out, inverters of 0
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if ({sel_out, std_inv_out, bad_trit, bad_sel} !== {2'd0, 2'd2, 1'b0, 1'b0}) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b expected=%b",
               {sel_out, std_inv_out, bad_trit, bad_sel}, 6'b001000);
    end
    rst_n = 1'b1;
    for (int s = 0; s < 32; s++) begin
      for (int x = 0; x < 4; x++) begin
        drive(x, s);
      end
    end
    wait (q.size() == 0);
    @(negedge clk);
    for (int x = 0; x < 3; x++) begin
      chain_check(x, 1'b1);
      chain_check(x, 1'b0);
    end
    finish_run();
  end
endmodule